// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block is the control sequencer of a two-channel data converter. It decides when the converter calibrates itself and when each channel is switched off. It also decides when the data leaving a channel can be trusted. Three asynchronous control pins feed it: a full power-down that shuts both channels, a power-down that shuts only the second channel, and a calibration request. Each pin passes through a two-flop synchroniser before the state machine acts on it.

The sequencer enforces the ordering rules between power-down, calibration and power-up:
- A calibration that has started always finishes before any power-down change takes effect.
- A calibration request that arrives while the converter is fully powered down is discarded, not kept for later.
- After reset the block sits in a pending power-on calibration state. That calibration starts only once full power-down is released.

The calibration engine is modelled as a fixed-length counter whose done pulse returns to the state machine. Leaving power-down, or finishing a calibration, leaves stale samples in the converter pipeline. A per-channel flush counter keeps that channel's data-valid flag low until the pipeline has drained.

Top module: `pdcal_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it: both channels are powered down (`ch_pwrdn_o` = 2'b11), both output enables are low, both data-valid flags are low, and busy and the start strobe are low.
- R2: After reset with full power-down low, the power-on calibration starts by itself within five cycles of reset release.
- R3: `cal_start_o` is a single-cycle pulse in the first cycle of a calibration. `cal_busy_o` stays high for exactly CAL_CYCLES consecutive cycles.
- R4: While full power-down is held from reset onward, no calibration starts. The power-on calibration starts once power-down is released.
- R5: Full power-down sets `ch_pwrdn_o` to 2'b11. Second-channel power-down alone sets it to 2'b10 (bit 1 is the second channel, bit 0 the first). Bit i of `out_en_o` is the inverse of bit i of `ch_pwrdn_o`, so a powered-down channel's outputs float. Channel 0's data stays valid throughout a second-channel power-down.
- R6: While a calibration runs, `ch_pwrdn_o` does not change. A power-down requested during the calibration takes effect in the same cycle that busy falls.
- R7: A rising edge of the calibration request while full power-down is asserted starts no calibration, either then or after power-down is released.
- R8: Calibration is started by a rising edge of the synchronised request while the sequencer is idle. A request held high starts only one calibration. A new edge during a calibration is ignored.
- R9: A channel's data-valid flag is low while the channel is powered down or a calibration runs. It rises exactly FLUSH_CYCLES cycles after the first cycle in which the channel is powered up and busy is low.
- R10: A power-down pin change reaches `ch_pwrdn_o` on the third rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pd_all_i | input | 1 | Full power-down request (both channels), asynchronous |
| pd_ch1_i | input | 1 | Second-channel-only power-down request, asynchronous |
| cal_req_i | input | 1 | Calibration request, rising-edge sensitive, asynchronous |
| cal_start_o | output | 1 | One-cycle strobe when a calibration run begins |
| cal_busy_o | output | 1 | High for the whole calibration run |
| ch_pwrdn_o | output | 2 | Per-channel power-down enables (bit 1 = second channel) |
| out_en_o | output | 2 | Per-channel data output driver enables (low = tristate) |
| data_valid_o | output | 2 | Per-channel pipeline-valid flag |

## Verification
The bench builds the sequencer with CAL_CYCLES = 12 and FLUSH_CYCLES = 7. These values are small enough that every calibration and every flush window can be counted cycle by cycle. CAL_CYCLES is also long enough that a power-down or a second request can be injected after the synchroniser delay and still land inside a running calibration. With these values the bench can measure the exact busy length and the exact flush delay per channel. It also reaches the deferred power-down case and the request that is dropped while busy.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        SEQ_PENDING = 2'd0,
        SEQ_CAL     = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cal_req;
        logic pd_ch1;
        logic pd_all;
    } ctrl_pins_t;

    localparam int CTRL_W = $bits(ctrl_pins_t);

    // Synchroniser reset value: power-down assumed asserted until seen low.
    localparam ctrl_pins_t CTRL_RST = '{cal_req: 1'b0, pd_ch1: 1'b1, pd_all: 1'b1};

    // Per-channel power-down wish: channel 0 follows full power-down only,
    // channel 1 follows either pin.
    function automatic logic [NUM_CH-1:0] ch_pd_request(input logic pd_all,
                                                        input logic pd_ch1);
        logic [NUM_CH-1:0] r;
        r[0] = pd_all;
        r[1] = pd_all | pd_ch1;
        return r;
    endfunction

endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                stab_q <= meta_q;
            end
        end

        assign q_o[b] = stab_q;
    end

endmodule

// File: rtl/pdcal_cal_timer.sv
module pdcal_cal_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign done_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pdcal_flush.sv
module pdcal_flush #(
    parameter int FLUSH_CYCLES = 34
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    output logic valid_o
);

    localparam int FW = $clog2(FLUSH_CYCLES + 1);
    localparam logic [FW-1:0] LOAD = FW'(FLUSH_CYCLES);

    logic [FW-1:0] cnt_q;
    logic          vld_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i) begin
            cnt_q <= LOAD;
            vld_q <= 1'b0;
        end else begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (cnt_q == FW'(1)) begin
                vld_q <= 1'b1;
            end
        end
    end

    assign valid_o = vld_q & ~hold_i;

endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq
    import pdcal_pkg::*;
#(
    parameter int CAL_CYCLES   = 4096,
    parameter int FLUSH_CYCLES = 34
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pd_all_i,
    input  logic              pd_ch1_i,
    input  logic              cal_req_i,
    output logic              cal_start_o,
    output logic              cal_busy_o,
    output logic [NUM_CH-1:0] ch_pwrdn_o,
    output logic [NUM_CH-1:0] out_en_o,
    output logic [NUM_CH-1:0] data_valid_o
);

    ctrl_pins_t        pins_raw;
    ctrl_pins_t        pins_s;
    logic              s_pd_all;
    logic              s_pd_ch1;
    logic              s_cal;
    logic              cal_prev_q;
    logic              cal_rise;
    logic [NUM_CH-1:0] pd_want;
    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              cal_go;
    logic              cal_done;
    logic              busy;
    logic              start_q;
    logic [NUM_CH-1:0] pwrdn_q;

    assign pins_raw = '{cal_req: cal_req_i, pd_ch1: pd_ch1_i, pd_all: pd_all_i};

    pdcal_sync #(
        .WIDTH   (CTRL_W),
        .RST_VAL (CTRL_RST)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign s_pd_all = pins_s.pd_all;
    assign s_pd_ch1 = pins_s.pd_ch1;
    assign s_cal    = pins_s.cal_req;
    assign cal_rise = s_cal & ~cal_prev_q;
    assign pd_want  = ch_pd_request(s_pd_all, s_pd_ch1);

    // Start decision: power-on calibration once released, later only on a
    // fresh request edge while idle and not fully powered down.
    always_comb begin
        cal_go  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            SEQ_PENDING: begin
                if (!s_pd_all) begin
                    cal_go  = 1'b1;
                    state_d = SEQ_CAL;
                end
            end
            SEQ_CAL: begin
                if (cal_done) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (cal_rise && !s_pd_all) begin
                    cal_go  = 1'b1;
                    state_d = SEQ_CAL;
                end
            end
            default: state_d = SEQ_PENDING;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= SEQ_PENDING;
            cal_prev_q <= 1'b0;
            start_q    <= 1'b0;
            pwrdn_q    <= '1;
        end else begin
            state_q    <= state_d;
            cal_prev_q <= s_cal;
            start_q    <= cal_go;
            // Power-down changes are frozen for the length of a calibration.
            if (state_q != SEQ_CAL || cal_done) begin
                pwrdn_q <= pd_want;
            end
        end
    end

    pdcal_cal_timer #(
        .CYCLES (CAL_CYCLES)
    ) u_cal (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (cal_go),
        .busy_o  (busy),
        .done_o  (cal_done)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pdcal_flush #(
            .FLUSH_CYCLES (FLUSH_CYCLES)
        ) u_flush (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .hold_i  (pwrdn_q[c] | busy),
            .valid_o (data_valid_o[c])
        );
        assign out_en_o[c] = ~pwrdn_q[c];
    end

    assign cal_start_o = start_q;
    assign cal_busy_o  = busy;
    assign ch_pwrdn_o  = pwrdn_q;

endmodule

// File: rtl/pdcal_seq_checker.sv
module pdcal_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       cal_start,
    input logic       busy,
    input logic [1:0] pwrdn,
    input logic [1:0] oe,
    input logic [1:0] valid,
    input logic       pd_all_s
);

    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> !cal_start);

    a_r3_start_opens_busy: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> (busy && !$past(busy)));

    a_r6_pd_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pwrdn));

    a_r7_no_cal_when_down: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(pd_all_s));

    a_r9_valid0_after_up: assert property (@(posedge clk) disable iff (rst)
        $rose(valid[0]) |-> ($past(oe[0]) && !$past(busy)));

    a_r9_valid1_after_up: assert property (@(posedge clk) disable iff (rst)
        $rose(valid[1]) |-> ($past(oe[1]) && !$past(busy)));

endmodule

bind pdcal_seq pdcal_seq_checker u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .cal_start (cal_start_o),
    .busy      (cal_busy_o),
    .pwrdn     (ch_pwrdn_o),
    .oe        (out_en_o),
    .valid     (data_valid_o),
    .pd_all_s  (s_pd_all)
);

// File: tb/pdcal_seq_tb.sv
`timescale 1ns/1ps
module pdcal_seq_tb;

    localparam int CAL = 12;
    localparam int FL  = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_all = 1'b0;
    logic       pd_ch1 = 1'b0;
    logic       cal_req = 1'b0;
    logic       cal_start;
    logic       busy;
    logic [1:0] pwrdn;
    logic [1:0] oe;
    logic [1:0] valid;

    int checks = 0;
    int errors = 0;
    int n_starts = 0;

    always #4 clk = ~clk;

    pdcal_seq #(.CAL_CYCLES(CAL), .FLUSH_CYCLES(FL)) u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .pd_all_i     (pd_all),
        .pd_ch1_i     (pd_ch1),
        .cal_req_i    (cal_req),
        .cal_start_o  (cal_start),
        .cal_busy_o   (busy),
        .ch_pwrdn_o   (pwrdn),
        .out_en_o     (oe),
        .data_valid_o (valid)
    );

    always @(negedge clk) if (!rst && cal_start) n_starts++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic pd);
        @(negedge clk);
        rst = 1'b1; pd_all = pd; pd_ch1 = 1'b0; cal_req = 1'b0;
        repeat (3) @(negedge clk);
        check(pwrdn == 2'b11 && oe == 2'b00, "R1 pwrdn/oe in reset", {pwrdn, oe}, 4'b1100);
        check(valid == 2'b00 && !busy && !cal_start, "R1 valid/busy in reset",
              {valid, busy, cal_start}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwrdn == 2'b11 && valid == 2'b00 && !busy, "R1 first cycle",
              {pwrdn, valid, busy}, 5'b11000);
    endtask

    // Waits for busy; returns cycles waited (capped).
    task automatic wait_busy(input int limit, output int n);
        n = 0;
        while (!busy && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Called on the first busy cycle: checks strobe and length, ends on the
    // first non-busy cycle.
    task automatic run_cal_measure();
        int n;
        check(cal_start == 1'b1, "R3 strobe in first busy cycle", cal_start, 1);
        n = 0;
        while (busy && n < 4 * CAL) begin
            n++;
            @(negedge clk);
            if (busy) check(!cal_start, "R3 strobe single cycle", cal_start, 0);
        end
        check(n == CAL, "R3 busy length", n, CAL);
    endtask

    task automatic measure_flush(input int ch);
        int m;
        m = 0;
        while (!valid[ch] && m < 100) begin
            @(negedge clk);
            m++;
        end
        check(m == FL, ch == 0 ? "R9 flush ch0" : "R9 flush ch1", m, FL);
    endtask

    task automatic t_power_on();
        int n;
        apply_reset(1'b0);
        wait_busy(5, n);
        check(busy == 1'b1, "R2 power-on cal starts", n, 2);
        run_cal_measure();
        check(pwrdn == 2'b00 && oe == 2'b11, "R5 all up after cal", {pwrdn, oe}, 4'b0011);
        measure_flush(0);
        check(valid == 2'b11, "R9 both valid", valid, 3);
    endtask

    task automatic t_pd_at_power_on();
        int n;
        int base;
        apply_reset(1'b1);
        base = n_starts;
        repeat (30) @(negedge clk);
        check(!busy && n_starts == base, "R4 no cal while held down", n_starts - base, 0);
        check(pwrdn == 2'b11 && oe == 2'b00, "R5 held down at power-on", {pwrdn, oe}, 4'b1100);
        pd_all = 1'b0;
        wait_busy(6, n);
        check(busy == 1'b1, "R4 cal after release", n, 3);
        run_cal_measure();
        measure_flush(0);
    endtask

    task automatic t_ch1_pd();
        @(negedge clk);
        pd_ch1 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pwrdn == 2'b00, "R10 not before third edge", pwrdn, 0);
        @(negedge clk);
        check(pwrdn == 2'b10, "R10 on third edge", pwrdn, 2);
        check(oe == 2'b01 && valid == 2'b01, "R5 second channel only",
              {oe, valid}, 4'b0101);
        repeat (5) @(negedge clk);
        check(valid[0] == 1'b1, "R5 ch0 stays valid", valid[0], 1);
        pd_ch1 = 1'b0;
        repeat (3) @(negedge clk);
        check(pwrdn == 2'b00 && oe == 2'b11, "R10 release on third edge", {pwrdn, oe}, 3);
        measure_flush(1);
        check(valid[0] == 1'b1, "R5 ch0 undisturbed", valid[0], 1);
    endtask

    task automatic t_full_pd_drops_req();
        int base;
        bit seen_busy;
        @(negedge clk);
        pd_all = 1'b1;
        repeat (4) @(negedge clk);
        check(pwrdn == 2'b11 && oe == 2'b00 && valid == 2'b00, "R5 full power-down",
              {pwrdn, oe, valid}, 6'b110000);
        base = n_starts;
        seen_busy = 1'b0;
        cal_req = 1'b1;
        repeat (4) @(negedge clk);
        cal_req = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (busy) seen_busy = 1'b1;
        end
        pd_all = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy) seen_busy = 1'b1;
        end
        check(!seen_busy && n_starts == base, "R7 request dropped", n_starts - base, 0);
        check(pwrdn == 2'b00 && valid == 2'b11, "R9 valid after release", {pwrdn, valid}, 3);
    endtask

    task automatic t_pd_during_cal();
        int n;
        bit moved;
        @(negedge clk);
        cal_req = 1'b1;
        wait_busy(6, n);
        check(busy == 1'b1, "R8 request starts cal", n, 3);
        cal_req = 1'b0;
        @(negedge clk);
        pd_all = 1'b1;
        moved = 1'b0;
        while (busy) begin
            if (pwrdn != 2'b00) moved = 1'b1;
            check(valid == 2'b00, "R9 invalid during cal", valid, 0);
            @(negedge clk);
        end
        check(!moved, "R6 power-down deferred", moved, 0);
        check(pwrdn == 2'b11, "R6 applied as busy falls", pwrdn, 3);
        @(negedge clk);
        pd_all = 1'b0;
        repeat (3) @(negedge clk);
        measure_flush(0);
        check(valid == 2'b11, "R9 both valid again", valid, 3);
    endtask

    task automatic t_level_request();
        int n;
        int base;
        base = n_starts;
        @(negedge clk);
        cal_req = 1'b1;
        wait_busy(6, n);
        repeat (2) @(negedge clk);
        cal_req = 1'b0;
        repeat (2) @(negedge clk);
        cal_req = 1'b1;
        n = 0;
        while (busy && n < 50) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
        check(n_starts - base == 1, "R8 one cal per held level", n_starts - base, 1);
        check(!busy, "R8 edge in cal ignored", busy, 0);
        cal_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_power_on();
        t_ch1_pd();
        t_full_pd_drops_req();
        t_pd_during_cal();
        t_level_request();
        t_pd_at_power_on();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule